// File: doc/BRIEF.md
# Store Buffer with Load Forwarding and Byte Merging

This block sits between a core's store pipeline and a data cache. An executed store is parked in a FIFO together with its word address, data and byte enables. The core does not wait for the cache to take it. Buffered stores are then presented to the cache strictly oldest first over a valid/ready write port.

While stores wait, a load can look up the buffer and take its bytes from the youngest buffered store to the same word, provided that store supplies every byte the load asks for. A narrow store that lands on the same aligned word as the newest entry is folded into that entry, so that a single wider write reaches the cache. This happens only if the newest entry is not the one already being offered to the cache.

A fence request blocks new stores and completes once the buffer has drained. The store input is also back-pressured while the buffer is full.

Both streaming interfaces follow valid/ready rules. A store transfers on a clock edge where `st_valid` and `st_ready` are both high. `st_ready` depends only on the buffer level and on `fence_req`, never on `st_valid`. A cache write transfers on an edge where `cw_valid` and `cw_ready` are both high. While `cw_ready` is low, the offered write is held unchanged. Addresses are word addresses. Byte lane i is data bits [8i+7:8i] and is qualified by enable bit i.

Top module: `store_buffer`

## Requirements
- R1: A store is accepted on a clock edge where `st_valid` and `st_ready` are both high. `st_ready` is high exactly when the buffer holds fewer than DEPTH entries and `fence_req` is low. An accepted store is offered on the cache port or visible to loads from the next cycle.
- R2: `cw_valid` is high whenever the buffer is not empty. The cache port always shows the oldest entry. Entries leave in the order they were allocated, one per edge with `cw_valid` and `cw_ready` both high. While `cw_ready` is low, `cw_addr`, `cw_data` and `cw_be` stay stable.
- R3: An accepted store whose word address equals that of the newest entry, while the buffer holds two or more entries, is merged into the newest entry and allocates nothing. Its enabled lanes replace the entry's bytes, and the entry's enables become the OR of both enable sets.
- R4: When the buffer holds exactly one entry, that entry is being offered to the cache and is never merged into. A store to the same word allocates a new entry.
- R5: With `ld_valid` high, if the youngest entry with a matching word address has enables covering every bit of `ld_be`, then in the same cycle `ld_hit` is 1, `ld_stall` is 0 and `ld_data` is that entry's data.
- R6: If the youngest matching entry lacks any byte requested by `ld_be`, `ld_stall` is 1 and `ld_hit` is 0. Older matching entries are not combined, even if they would cover the load.
- R7: A load with no matching entry, or with `ld_valid` low, gives `ld_hit` 0 and `ld_stall` 0.
- R8: `sb_full` is high when DEPTH entries are buffered. While it is high, no store is accepted, and a store held on the input during that time never reaches the cache.
- R9: `fence_done` is high exactly when `fence_req` is high and the buffer is empty. While `fence_req` is high, no store is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data, lane i at bits [8i+7:8i] |
| st_be | input | DW/8 | Store byte enables |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_be | input | DW/8 | Bytes the load needs |
| ld_hit | output | 1 | Load fully served from buffer |
| ld_stall | output | 1 | Load partially covered, must wait |
| ld_data | output | DW | Forwarded data, zero when no hit |
| cw_valid | output | 1 | Cache write offered |
| cw_ready | input | 1 | Cache accepts write |
| cw_addr | output | AW | Cache write word address |
| cw_data | output | DW | Cache write data |
| cw_be | output | DW/8 | Cache write byte enables |
| fence_req | input | 1 | Fence pending, drain buffer |
| fence_done | output | 1 | Fence may complete |
| sb_full | output | 1 | Buffer holds DEPTH entries |

## Verification
Load lookup is combinational over the stored entries. `ld_hit`, `ld_stall` and `ld_data` are due in the same cycle the load inputs are applied. They reflect stores accepted at earlier edges, not a store taken at the coming edge. A store accepted at an edge changes `cw_valid`, `sb_full` and the lookup result right after that edge. A write is removed at the edge where both valid and ready are high, so `fence_done` rises right after the edge that takes the last entry. The bench changes inputs one time unit after a rising edge and samples every output at the following falling edge, so each check sees the settled result of exactly one edge. A scoreboard compares every cache write, in order, against the writes predicted from R2 to R4.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    LK_MISS = 2'd0,
    LK_HIT  = 2'd1,
    LK_PART = 2'd2
  } lk_t;
endpackage

// File: rtl/sb_lane_merge.sv
module sb_lane_merge #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic [DW-1:0] old_data,
  input  logic [NB-1:0] old_be,
  input  logic [DW-1:0] new_data,
  input  logic [NB-1:0] new_be,
  output logic [DW-1:0] mrg_data,
  output logic [NB-1:0] mrg_be
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign mrg_data[8*i +: 8] = new_be[i] ? new_data[8*i +: 8] : old_data[8*i +: 8];
  end
  assign mrg_be = old_be | new_be;
endmodule

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int DEPTH = 8,
  parameter int AW = 30,
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [NB-1:0]             wr_be,
  input  logic                      pop,
  output logic [DEPTH-1:0][AW-1:0]  q_addr,
  output logic [DEPTH-1:0][DW-1:0]  q_data,
  output logic [DEPTH-1:0][NB-1:0]  q_be,
  output logic [PW-1:0]             head_ptr,
  output logic [PW:0]               count
);
  localparam logic [PW:0]   FULL_CNT = (PW+1)'(DEPTH);
  localparam logic [PW:0]   ONE_CNT  = (PW+1)'(1);
  localparam logic [PW-1:0] LAST_IX  = PW'(DEPTH - 1);

  logic [PW-1:0] hd, tl, nw;
  logic [PW:0]   cnt;
  logic          merge_ok, alloc;
  logic [DW-1:0] mrg_data;
  logic [NB-1:0] mrg_be;

  // newest entry index, wrapping for any depth
  assign nw       = (tl == '0) ? LAST_IX : tl - 1'b1;
  // merge only when the newest entry is not the head being offered
  assign merge_ok = (cnt > ONE_CNT) && (q_addr[nw] == wr_addr);
  assign alloc    = wr && !merge_ok;

  sb_lane_merge #(.DW(DW)) u_merge (
    .old_data (q_data[nw]),
    .old_be   (q_be[nw]),
    .new_data (wr_data),
    .new_be   (wr_be),
    .mrg_data (mrg_data),
    .mrg_be   (mrg_be)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd  <= '0;
      tl  <= '0;
      cnt <= '0;
    end else begin
      if (alloc) tl <= (tl == LAST_IX) ? '0 : tl + 1'b1;
      if (pop)   hd <= (hd == LAST_IX) ? '0 : hd + 1'b1;
      unique case ({alloc, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      if (merge_ok) begin
        q_data[nw] <= mrg_data;
        q_be[nw]   <= mrg_be;
      end else begin
        q_addr[tl] <= wr_addr;
        q_data[tl] <= wr_data;
        q_be[tl]   <= wr_be;
      end
    end
  end

  assign head_ptr = hd;
  assign count    = cnt;

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  a_r3_merge_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    wr && merge_ok && !pop |=> cnt == $past(cnt));

  a_r4_alloc_grows_level: assert property (@(posedge clk) disable iff (!rst_n)
    alloc && !pop |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/sb_lookup.sv
module sb_lookup #(
  parameter int DEPTH = 8,
  parameter int AW = 30,
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][AW-1:0] q_addr,
  input  logic [DEPTH-1:0][DW-1:0] q_data,
  input  logic [DEPTH-1:0][NB-1:0] q_be,
  input  logic [PW-1:0]            head_ptr,
  input  logic [PW:0]              count,
  input  logic                     ld_valid,
  input  logic [AW-1:0]            ld_addr,
  input  logic [NB-1:0]            ld_be,
  output sb_pkg::lk_t              result,
  output logic [DW-1:0]            fwd_data
);
  logic          found;
  logic [DW-1:0] sel_data;
  logic [NB-1:0] sel_be;
  logic [PW-1:0] ix;
  int            k;

  // scan oldest to youngest so the last match wins
  always_comb begin
    found    = 1'b0;
    sel_data = '0;
    sel_be   = '0;
    ix       = '0;
    k        = 0;
    for (int i = 0; i < DEPTH; i++) begin
      k = int'(head_ptr) + i;
      if (k >= DEPTH) k = k - DEPTH;
      ix = PW'(k);
      if (((PW+1)'(i) < count) && (q_addr[ix] == ld_addr)) begin
        found    = 1'b1;
        sel_data = q_data[ix];
        sel_be   = q_be[ix];
      end
    end
  end

  always_comb begin
    result   = sb_pkg::LK_MISS;
    fwd_data = '0;
    if (ld_valid && found) begin
      if ((ld_be & ~sel_be) == '0) begin
        result   = sb_pkg::LK_HIT;
        fwd_data = sel_data;
      end else begin
        result = sb_pkg::LK_PART;
      end
    end
  end
endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
  parameter int DEPTH = 8,
  parameter int AW = 30,
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [NB-1:0] st_be,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [NB-1:0] ld_be,
  output logic          ld_hit,
  output logic          ld_stall,
  output logic [DW-1:0] ld_data,
  output logic          cw_valid,
  input  logic          cw_ready,
  output logic [AW-1:0] cw_addr,
  output logic [DW-1:0] cw_data,
  output logic [NB-1:0] cw_be,
  input  logic          fence_req,
  output logic          fence_done,
  output logic          sb_full
);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  logic [DEPTH-1:0][AW-1:0] q_addr;
  logic [DEPTH-1:0][DW-1:0] q_data;
  logic [DEPTH-1:0][NB-1:0] q_be;
  logic [PW-1:0]            head_ptr;
  logic [PW:0]              count;
  logic                     st_fire, cw_fire;
  sb_pkg::lk_t              lk;

  assign sb_full    = (count == FULL_CNT);
  assign st_ready   = !sb_full && !fence_req;
  assign st_fire    = st_valid && st_ready;
  assign cw_valid   = (count != '0);
  assign cw_fire    = cw_valid && cw_ready;
  assign fence_done = fence_req && (count == '0);

  sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (st_fire),
    .wr_addr  (st_addr),
    .wr_data  (st_data),
    .wr_be    (st_be),
    .pop      (cw_fire),
    .q_addr   (q_addr),
    .q_data   (q_data),
    .q_be     (q_be),
    .head_ptr (head_ptr),
    .count    (count)
  );

  assign cw_addr = q_addr[head_ptr];
  assign cw_data = q_data[head_ptr];
  assign cw_be   = q_be[head_ptr];

  sb_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lookup (
    .q_addr   (q_addr),
    .q_data   (q_data),
    .q_be     (q_be),
    .head_ptr (head_ptr),
    .count    (count),
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr),
    .ld_be    (ld_be),
    .result   (lk),
    .fwd_data (ld_data)
  );

  assign ld_hit   = (lk == sb_pkg::LK_HIT);
  assign ld_stall = (lk == sb_pkg::LK_PART);

  a_r1_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    st_fire |=> cw_valid);

  a_r2_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready |=> cw_valid && $stable(cw_addr) && $stable(cw_data) && $stable(cw_be));

  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_hit, ld_stall}));

  a_r7_idle_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !ld_hit && !ld_stall);

  a_r9_fence_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req |=> count <= $past(count));
endmodule

// File: tb/sim_store_buffer.sv
module sim_store_buffer;
  localparam int DEPTH = 8;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0;
  logic st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [NB-1:0] st_be = '0;
  logic ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [NB-1:0] ld_be = '0;
  logic ld_hit, ld_stall;
  logic [DW-1:0] ld_data;
  logic cw_valid;
  logic cw_ready = 1'b0;
  logic [AW-1:0] cw_addr;
  logic [DW-1:0] cw_data;
  logic [NB-1:0] cw_be;
  logic fence_req = 1'b0;
  logic fence_done, sb_full;

  always #5 clk = ~clk;

  store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data),
    .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_addr(cw_addr), .cw_data(cw_data), .cw_be(cw_be),
    .fence_req(fence_req), .fence_done(fence_done), .sb_full(sb_full)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [AW-1:0] exp_a[$];
  logic [DW-1:0] exp_d[$];
  logic [NB-1:0] exp_b[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] b);
    exp_a.push_back(a);
    exp_d.push_back(d);
    exp_b.push_back(b);
  endtask

  // monitor: a write fires at the rising edge following this falling edge
  always @(negedge clk) begin
    if (rst_n && cw_valid && cw_ready) begin
      if (exp_a.size() == 0) begin
        chk(1'b0, "R2", "unexpected cache write addr", 64'(cw_addr), 64'h0);
      end else begin
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        logic [NB-1:0] eb;
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        eb = exp_b.pop_front();
        chk(cw_addr == ea && cw_data == ed && cw_be == eb, "R2",
            "cache write {addr,data,be}", {cw_addr, cw_data, cw_be}, {ea, ed, eb});
      end
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] b);
    st_valid = 1'b1;
    st_addr  = a;
    st_data  = d;
    st_be    = b;
    for (int n = 0; n < 1000; n++) begin
      @(negedge clk);
      if (st_ready) break;
    end
    tick();
    st_valid = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [NB-1:0] b,
                         input bit e_hit, input bit e_stall, input logic [DW-1:0] e_data,
                         input string req);
    ld_valid = 1'b1;
    ld_addr  = a;
    ld_be    = b;
    @(negedge clk);
    chk(ld_hit == e_hit && ld_stall == e_stall, req, "load {hit,stall}",
        64'({ld_hit, ld_stall}), 64'({e_hit, e_stall}));
    if (e_hit) chk(ld_data == e_data, req, "forwarded data", 64'(ld_data), 64'(e_data));
    tick();
    ld_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    cw_ready = 1'b1;
    for (int n = 0; n < 1000; n++) begin
      @(negedge clk);
      if (!cw_valid) break;
    end
    tick();
    cw_ready = 1'b0;
    chk(exp_a.size() == 0, req, "writes still expected", 64'(exp_a.size()), 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk(cw_valid == 1'b0, "R2", "cw_valid after reset", 64'(cw_valid), 64'h0);
    chk(st_ready == 1'b1, "R1", "st_ready after reset", 64'(st_ready), 64'h1);
    chk(sb_full == 1'b0, "R8", "sb_full after reset", 64'(sb_full), 64'h0);
    chk(fence_done == 1'b0, "R9", "fence_done after reset", 64'(fence_done), 64'h0);
    tick();

    // forwarding, merging and youngest-match, cache stalled
    do_store(30'h10, 32'h11223344, 4'b1111);
    @(negedge clk);
    chk(cw_valid == 1'b1, "R1", "cw_valid after first store", 64'(cw_valid), 64'h1);
    tick();
    do_load(30'h10, 4'b1111, 1'b1, 1'b0, 32'h11223344, "R5");
    do_store(30'h20, 32'h000000BB, 4'b0001);
    do_store(30'h20, 32'h0000AA00, 4'b0010);
    do_load(30'h20, 4'b0011, 1'b1, 1'b0, 32'h0000AABB, "R3");
    do_load(30'h20, 4'b0100, 1'b0, 1'b1, 32'h0, "R6");
    do_store(30'h10, 32'h77000000, 4'b1000);
    do_load(30'h10, 4'b1000, 1'b1, 1'b0, 32'h77000000, "R5");
    do_load(30'h10, 4'b0001, 1'b0, 1'b1, 32'h0, "R6");
    do_load(30'h30, 4'b1111, 1'b0, 1'b0, 32'h0, "R7");
    ld_addr = 30'h10;
    ld_be = 4'b1000;
    @(negedge clk);
    chk(!ld_hit && !ld_stall, "R7", "idle load outputs", 64'({ld_hit, ld_stall}), 64'h0);
    tick();
    expect_wr(30'h10, 32'h11223344, 4'b1111);
    expect_wr(30'h20, 32'h0000AABB, 4'b0011);
    expect_wr(30'h10, 32'h77000000, 4'b1000);
    drain("R3");

    // a lone head entry is never merged into
    do_store(30'h40, 32'h000000CC, 4'b0001);
    do_store(30'h40, 32'h0000DD00, 4'b0010);
    do_store(30'h40, 32'h00EE0000, 4'b0100);
    expect_wr(30'h40, 32'h000000CC, 4'b0001);
    expect_wr(30'h40, 32'h00EEDD00, 4'b0110);
    drain("R4");

    // full buffer back-pressure
    for (int i = 0; i < DEPTH; i++)
      do_store(30'h100 + 30'(i), 32'h01010101 * 32'(i + 1), 4'b1111);
    @(negedge clk);
    chk(sb_full == 1'b1, "R8", "sb_full at DEPTH entries", 64'(sb_full), 64'h1);
    chk(st_ready == 1'b0, "R8", "st_ready when full", 64'(st_ready), 64'h0);
    tick();
    st_valid = 1'b1;
    st_addr = 30'h1FF;
    st_data = 32'hDEADBEEF;
    st_be = 4'b1111;
    repeat (3) tick();
    st_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      expect_wr(30'h100 + 30'(i), 32'h01010101 * 32'(i + 1), 4'b1111);
    drain("R8");

    // fence drain
    do_store(30'h200, 32'hA5A5A5A5, 4'b1111);
    do_store(30'h204, 32'h5A5A5A5A, 4'b1111);
    fence_req = 1'b1;
    @(negedge clk);
    chk(fence_done == 1'b0, "R9", "fence_done with entries", 64'(fence_done), 64'h0);
    chk(st_ready == 1'b0, "R9", "st_ready during fence", 64'(st_ready), 64'h0);
    tick();
    expect_wr(30'h200, 32'hA5A5A5A5, 4'b1111);
    expect_wr(30'h204, 32'h5A5A5A5A, 4'b1111);
    drain("R9");
    @(negedge clk);
    chk(fence_done == 1'b1, "R9", "fence_done once empty", 64'(fence_done), 64'h1);
    tick();
    fence_req = 1'b0;
    @(negedge clk);
    chk(st_ready == 1'b1, "R1", "st_ready after fence", 64'(st_ready), 64'h1);
    chk(fence_done == 1'b0, "R9", "fence_done without request", 64'(fence_done), 64'h0);
    tick();

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule